// File: doc/BRIEF.md
# Display RAM Address Unit with Modify-Read

This block holds the page register and the column counter that address a display RAM of nine pages by 132 columns. Pages 0 to 7 carry pixel bytes and page 8 is a single-row icon page. A command decoder ahead of it hands over one decoded command per cycle. The commands can load the page, load either half of the column, enter or leave a modify-read mode, or return the address to its origin. Separate read and write strobes mark data transfers. The block presents the current page and column and an access-enable that tells the RAM port whether the address points at real storage.

Each transfer moves the column forward by one. At the end of the column range the counter steps once past the last column and then stays there, locked, until software loads a new column value. Modify-read mode serves cursor work. While it is active, reads leave the column alone and writes still advance it. Leaving the mode puts back the column held at entry, so the same span can be read and rewritten again.

All inputs are plain level signals that are sampled on every rising edge. There is no back-pressure: the block takes every command and every strobe in the cycle it is presented. A command and a strobe in the same cycle are not both acted on, because the command wins.

Top module: `dram_addr_unit`

## Requirements
- R1: While rst_n is low and after it is released, the page is 0, the column is 0 and modify-read mode is off, so a read then advances the column.
- R2: A command with cmd_op = 1 loads cmd_arg into the page register one cycle later and leaves the column unchanged. Transfers never change the page.
- R3: acc_en is high exactly when the page is at most 8 and the column is at most 131. Page values 9 to 15 and column values 132 to 255 drive it low.
- R4: cmd_op = 2 loads cmd_arg into column bits 7:4 and keeps bits 3:0. cmd_op = 3 loads cmd_arg into bits 3:0 and keeps bits 7:4.
- R5: With cmd_valid low, a cycle with rd_stb or wr_stb high (or both) increments the column by exactly one.
- R6: A transfer at column 131 moves the column to 132. Any column above 131 is locked, and further transfers leave it unchanged. Only a column nibble load can change a locked column.
- R7: cmd_op = 4 enters modify-read mode. In that mode a read alone does not change the column, and a write still increments it.
- R8: cmd_op = 5 restores the column saved at the first entry into the mode and ends the mode. cmd_op = 4 while the mode is active does not re-save, and cmd_op = 5 outside the mode changes nothing.
- R9: cmd_op = 6 sets the page and the column to 0 and ends modify-read mode.
- R10: In a cycle with cmd_valid high, rd_stb and wr_stb are ignored. cmd_op = 0 and cmd_op = 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 page, 2 column high, 3 column low, 4 enter modify-read, 5 leave modify-read, 6 address reset) |
| cmd_arg | input | 4 | Nibble argument for the page and column loads |
| rd_stb | input | 1 | Data read transfer this cycle |
| wr_stb | input | 1 | Data write transfer this cycle |
| page_o | output | 4 | Current page |
| col_o | output | 8 | Current column |
| acc_en | output | 1 | Address points at existing RAM |

## Verification
Every command and strobe is seen at a rising edge. Its effect on page_o and col_o is visible after that same edge, one cycle later, and acc_en follows combinationally from the new registered address in the same cycle. The bench drives inputs just after a falling edge and advances its behavioural model at that moment. It compares all three outputs at the next falling edge, so each result is checked in the cycle it becomes due. The scripted cases include the 131-to-132 lock, the restore across a lock, a repeated mode entry, and a command that hides a strobe. A long pseudo-random run follows them.

// File: rtl/dram_addr_pkg.sv
package dram_addr_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_PAGE     = 3'd1,
    OP_COL_HI   = 3'd2,
    OP_COL_LO   = 3'd3,
    OP_MR_ENTER = 3'd4,
    OP_MR_EXIT  = 3'd5,
    OP_RESET    = 3'd6,
    OP_SPARE    = 3'd7
  } addr_op_e;
endpackage

// File: rtl/dram_page_reg.sv
module dram_page_reg #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page_q <= '0;
    else if (clear) page_q <= '0;
    else if (load)  page_q <= din;
  end
endmodule

// File: rtl/dram_col_ctr.sv
module dram_col_ctr #(
  parameter int NIB_W    = 4,
  parameter int NUM_COLS = 132
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 restore,
  input  logic [2*NIB_W-1:0]   restore_val,
  input  logic                 load_hi,
  input  logic                 load_lo,
  input  logic [NIB_W-1:0]     nib,
  input  logic                 step,
  output logic [2*NIB_W-1:0]   col_q,
  output logic                 locked
);
  localparam int COL_W = 2 * NIB_W;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  logic [COL_W-1:0] col_d;

  assign locked = (col_q > LAST_COL);

  always_comb begin
    col_d = col_q;
    if (clear)                  col_d = '0;
    else if (restore)           col_d = restore_val;
    else if (load_hi)           col_d = {nib, col_q[NIB_W-1:0]};
    else if (load_lo)           col_d = {col_q[COL_W-1:NIB_W], nib};
    else if (step && !locked)   col_d = col_q + COL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end
endmodule

// File: rtl/dram_mr_save.sv
module dram_mr_save #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             leave,
  input  logic             clear,
  input  logic [COL_W-1:0] col_i,
  output logic             active_q,
  output logic [COL_W-1:0] saved_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      saved_q  <= '0;
    end else if (clear || leave) begin
      active_q <= 1'b0;
    end else if (enter && !active_q) begin
      active_q <= 1'b1;
      saved_q  <= col_i;
    end
  end
endmodule

// File: rtl/dram_addr_unit.sv
module dram_addr_unit #(
  parameter int NIB_W     = 4,
  parameter int NUM_COLS  = 132,
  parameter int NUM_PAGES = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [NIB_W-1:0]   cmd_arg,
  input  logic               rd_stb,
  input  logic               wr_stb,
  output logic [NIB_W-1:0]   page_o,
  output logic [2*NIB_W-1:0] col_o,
  output logic               acc_en
);
  import dram_addr_pkg::*;

  localparam int COL_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] LAST_PAGE = NIB_W'(NUM_PAGES - 1);

  addr_op_e op;
  logic     is_page, is_hi, is_lo, is_enter, is_exit, is_clr;
  logic     mr_active, locked, step;
  logic [COL_W-1:0] saved_col;

  assign op       = addr_op_e'(cmd_op);
  assign is_page  = cmd_valid && (op == OP_PAGE);
  assign is_hi    = cmd_valid && (op == OP_COL_HI);
  assign is_lo    = cmd_valid && (op == OP_COL_LO);
  assign is_enter = cmd_valid && (op == OP_MR_ENTER);
  assign is_exit  = cmd_valid && (op == OP_MR_EXIT) && mr_active;
  assign is_clr   = cmd_valid && (op == OP_RESET);

  // a read only advances outside modify-read; a write always does
  assign step = !cmd_valid && (wr_stb || (rd_stb && !mr_active));

  dram_page_reg #(.PAGE_W(NIB_W)) u_page (
    .clk(clk), .rst_n(rst_n), .load(is_page), .clear(is_clr),
    .din(cmd_arg), .page_q(page_o)
  );

  dram_col_ctr #(.NIB_W(NIB_W), .NUM_COLS(NUM_COLS)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(is_clr), .restore(is_exit),
    .restore_val(saved_col), .load_hi(is_hi), .load_lo(is_lo),
    .nib(cmd_arg), .step(step), .col_q(col_o), .locked(locked)
  );

  dram_mr_save #(.COL_W(COL_W)) u_mr (
    .clk(clk), .rst_n(rst_n), .enter(is_enter), .leave(is_exit),
    .clear(is_clr), .col_i(col_o), .active_q(mr_active), .saved_q(saved_col)
  );

  assign acc_en = !locked && (page_o <= LAST_PAGE);
endmodule

// File: rtl/dram_addr_unit_chk.sv
module dram_addr_unit_chk #(
  parameter int NIB_W     = 4,
  parameter int NUM_COLS  = 132,
  parameter int NUM_PAGES = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [2:0]         cmd_op,
  input logic [NIB_W-1:0]   cmd_arg,
  input logic               rd_stb,
  input logic               wr_stb,
  input logic [NIB_W-1:0]   page_o,
  input logic [2*NIB_W-1:0] col_o,
  input logic               acc_en,
  input logic               mr_active
);
  localparam int COL_W = 2 * NIB_W;
  localparam logic [COL_W-1:0] LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [NIB_W-1:0] LAST_PAGE = NIB_W'(NUM_PAGES - 1);

  a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> (page_o == $past(cmd_arg)) && $stable(col_o));

  a_r2_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(page_o));

  a_r3_enable_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> (col_o <= LAST_COL) && (page_o <= LAST_PAGE));

  a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=>
      (col_o[COL_W-1:NIB_W] == $past(cmd_arg)) && (col_o[NIB_W-1:0] == $past(col_o[NIB_W-1:0])));

  a_r5_write_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && wr_stb && col_o <= LAST_COL) |=> col_o == $past(col_o) + COL_W'(1));

  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && col_o > LAST_COL) |=> $stable(col_o));

  a_r7_read_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && rd_stb && !wr_stb && mr_active) |=> $stable(col_o));

  a_r9_addr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6) |=> (col_o == '0) && (page_o == '0) && !mr_active);

  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd7)) |=> $stable(col_o) && $stable(page_o));
endmodule

bind dram_addr_unit dram_addr_unit_chk #(
  .NIB_W(NIB_W), .NUM_COLS(NUM_COLS), .NUM_PAGES(NUM_PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_arg(cmd_arg), .rd_stb(rd_stb), .wr_stb(wr_stb), .page_o(page_o),
  .col_o(col_o), .acc_en(acc_en), .mr_active(mr_active)
);

// File: tb/dram_addr_unit_bench.sv
`timescale 1ns/1ps
module dram_addr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [3:0] cmd_arg = 4'd0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [3:0] page_o;
  logic [7:0] col_o;
  logic       acc_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_page = 0, m_col = 0, m_save = 0;
  bit m_mr = 1'b0;

  always #2 clk = ~clk;

  dram_addr_unit u_dram_addr_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .page_o(page_o), .col_o(col_o), .acc_en(acc_en)
  );

  task automatic compare(input string tag);
    bit exp_en;
    exp_en = (m_page <= 8) && (m_col <= 131);
    checks++;
    if (int'(page_o) != m_page) begin
      errors++; $display("FAIL %s page actual=%0d expected=%0d", tag, page_o, m_page);
    end
    checks++;
    if (int'(col_o) != m_col) begin
      errors++; $display("FAIL %s column actual=%0d expected=%0d", tag, col_o, m_col);
    end
    checks++;
    if (acc_en != exp_en) begin
      errors++; $display("FAIL %s R3 acc_en actual=%0b expected=%0b", tag, acc_en, exp_en);
    end
  endtask

  task automatic model(input bit v, input int op, input int arg, input bit rd, input bit wr);
    if (v) begin
      case (op)
        1: m_page = arg;
        2: m_col = (arg << 4) | (m_col & 15);
        3: m_col = (m_col & 240) | arg;
        4: if (!m_mr) begin m_mr = 1'b1; m_save = m_col; end
        5: if (m_mr) begin m_mr = 1'b0; m_col = m_save; end
        6: begin m_page = 0; m_col = 0; m_mr = 1'b0; end
        default: ;
      endcase
    end else if (wr || (rd && !m_mr)) begin
      if (m_col <= 131) m_col = m_col + 1;
    end
  endtask

  // inputs applied after a falling edge; outputs compared at the next one
  task automatic step(input bit v, input int op, input int arg,
                      input bit rd, input bit wr, input string tag);
    cmd_valid = v; cmd_op = 3'(op); cmd_arg = 4'(arg); rd_stb = rd; wr_stb = wr;
    model(v, op, arg, rd, wr);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cmd(input int op, input int arg, input string tag);
    step(1'b1, op, arg, 1'b0, 1'b0, tag);
  endtask

  task automatic xfer(input bit rd, input bit wr, input string tag);
    step(1'b0, 0, 0, rd, wr, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    xfer(1, 0, "R1 read after reset advances");

    // R5 plain increments
    for (int i = 0; i < 3; i++) xfer(0, 1, "R5 write");
    xfer(1, 0, "R5 read");
    xfer(1, 1, "R5 read and write once");

    // R2 / R3 page loads
    cmd(1, 5, "R2 page 5");
    xfer(0, 1, "R2 page unchanged by write");
    cmd(1, 8, "R3 icon page enabled");
    cmd(1, 9, "R3 page 9 disabled");
    cmd(1, 15, "R3 page 15 disabled");
    cmd(1, 2, "R2 page 2");

    // R4 / R6 nibbles and lock
    cmd(2, 8, "R4 high nibble");
    cmd(3, 2, "R4 low nibble");
    xfer(0, 1, "R6 to last column");
    xfer(0, 1, "R6 step past last");
    xfer(0, 1, "R6 locked write");
    xfer(1, 0, "R6 locked read");
    cmd(3, 0, "R6 unlock by nibble load");
    xfer(0, 1, "R6 counts after unlock");
    cmd(2, 15, "R3 column above range");
    xfer(1, 0, "R6 high column locked");

    // R10 command hides strobes
    cmd(2, 1, "R4 high nibble 1");
    step(1'b1, 0, 9, 1'b1, 1'b1, "R10 nop with strobes");
    step(1'b1, 7, 3, 1'b0, 1'b1, "R10 spare code");

    // R7 / R8 modify-read
    cmd(3, 5, "R4 low nibble 5");
    cmd(4, 0, "R7 enter");
    for (int i = 0; i < 3; i++) xfer(1, 0, "R7 read frozen");
    xfer(0, 1, "R7 write advances");
    xfer(0, 1, "R7 write advances");
    cmd(4, 0, "R8 repeated enter");
    xfer(0, 1, "R7 write advances");
    cmd(5, 0, "R8 restore");
    xfer(1, 0, "R8 read after exit");
    cmd(5, 0, "R8 exit outside mode");
    cmd(2, 8, "R4 high 8");
    cmd(3, 2, "R4 low 2");
    cmd(4, 0, "R7 enter near end");
    for (int i = 0; i < 3; i++) xfer(0, 1, "R6 write to lock in mode");
    cmd(5, 0, "R8 restore from lock");

    // R9 address reset
    cmd(1, 7, "R2 page 7");
    cmd(4, 0, "R7 enter");
    cmd(6, 0, "R9 address reset");
    xfer(1, 0, "R9 mode cleared");

    // R1 hardware reset mid-run
    cmd(1, 3, "R2 page 3");
    cmd(4, 0, "R7 enter");
    rst_n = 1'b0; m_page = 0; m_col = 0; m_mr = 1'b0; m_save = 0;
    @(negedge clk);
    compare("R1 mid-run reset");
    rst_n = 1'b1;
    xfer(1, 0, "R1 read after mid-run reset");

    // pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 7) step(1'b0, 0, 0, 1'($urandom), 1'($urandom), "R5 random");
      else       step(1'b1, int'($urandom % 8), int'($urandom % 16),
                      1'($urandom), 1'($urandom), "R8 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule